// File: doc/BRIEF.md
# BCD Up/Down Event Counter

This block counts discrete events in three-digit binary-coded decimal. It has two level inputs, one for counting up and one for counting down. Each input adds or takes away one count only when it goes from low to high. A level that stays high counts once. It has to drop and rise again before it can count a second time. The counter has no notion of elapsed time, and its value stays where it is while both conditions are low.

All results appear on one 16-bit status word. The low twelve bits hold the count as packed BCD digits. Above them are four flags:

- a sticky wrap flag, set on overflow past 999 or underflow below 000;
- a done flag, set while the count is at or above a BCD preset input;
- a down-condition enable flag;
- an up-condition enable flag.

A synchronous reset clears the count and the wrap flag. The two enable flags keep tracking their conditions during reset.

Top module: `bcd_event_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count (bits 11:0) becomes 000 and the wrap flag (bit 12) becomes 0. A rising edge of a condition seen during reset is not counted.
- R2: A low-to-high change of `upCond`, with no low-to-high change of `downCond` at the same edge, raises the count by one in decimal. The carry ripples across all digits in that one clock cycle.
- R3: A low-to-high change of `downCond`, with no low-to-high change of `upCond` at the same edge, lowers the count by one in decimal. The borrow ripples across all digits in that one clock cycle.
- R4: A condition that stays high adds no further counts. It must go low for at least one clock and then high again before it counts again.
- R5: An up count from 999 wraps to 000, and a down count from 000 wraps to 999. Either wrap sets bit 12, which then stays at 1 until reset.
- R6: Bit 13 (done) is 1 exactly when the 12-bit count, read as an unsigned number, is greater than or equal to `presetBcd` read the same way.
- R7: Bit 15 equals the value `upCond` had at the previous rising clock edge, and bit 14 equals the value `downCond` had at that edge. Both do this in reset too.
- R8: When `upCond` and `downCond` both rise at the same edge, the two counts cancel. The count and the wrap flag do not change.
- R9: While neither condition has a low-to-high change, the count holds its value.
- R10: The count is three packed BCD digits, with the least significant digit in bits 3:0 and the most significant in bits 11:8. Each digit stays within 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upCond | input | 1 | Up-count condition level |
| downCond | input | 1 | Down-count condition level |
| presetBcd | input | 12 | Preset value, three BCD digits, compared against the count |
| statusWord | output | 16 | {upEn, downEn, done, wrap, count[11:0]} |

## Verification
The assertions assume that `presetBcd` holds valid BCD. They also assume that the conditions are stable around the clock edge, so each rising edge is seen at exactly one clock. The bench changes inputs only on the falling clock edge and uses only decimal presets.

The bench holds every pulse high for a full cycle and low for a full cycle before the next rise. It adds separate cases for held-high levels and for edges on both conditions at once. It sweeps the counter through every value in both directions, and across both wraps.

// File: rtl/bcd_event_counter_pkg.sv
package bcd_event_counter_pkg;
  // Strobes from control to datapath; at most one is high per cycle
  typedef struct packed {
    logic incr;
    logic decr;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcd_count_ctrl.sv
module bcd_count_ctrl
  import bcd_event_counter_pkg::*;
(
  input  logic         clk,
  input  logic         upCond,
  input  logic         downCond,
  output ctrlStrobes_t strobes,
  output logic         upEn,
  output logic         downEn
);
  logic upPrev;
  logic downPrev;
  logic upRise;
  logic downRise;

  // Condition history is not reset so the enable flags keep tracking
  always_ff @(posedge clk) begin
    upPrev   <= upCond;
    downPrev <= downCond;
  end

  assign upRise   = upCond & ~upPrev;
  assign downRise = downCond & ~downPrev;

  // Simultaneous rises cancel
  always_comb begin
    strobes.incr = upRise & ~downRise;
    strobes.decr = downRise & ~upRise;
  end

  assign upEn   = upPrev;
  assign downEn = downPrev;
endmodule

// File: rtl/bcd_count_datapath.sv
module bcd_count_datapath
  import bcd_event_counter_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int ACC_W = 4 * NUM_DIGITS
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [ACC_W-1:0] presetBcd,
  output logic [ACC_W-1:0] accBcd,
  output logic             doneFlag,
  output logic             wrapFlag
);
  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] incVal;
  logic [ACC_W-1:0] decVal;
  logic             incCarry;
  logic             decBorrow;

  // Ripple increment: a digit at 9 rolls to 0 and passes the carry on
  always_comb begin
    logic carry;
    logic [3:0] digit;
    carry  = 1'b1;
    incVal = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      digit = accQ[4*i +: 4];
      if (carry) begin
        if (digit == 4'd9) begin
          incVal[4*i +: 4] = 4'd0;
        end else begin
          incVal[4*i +: 4] = 4'(digit + 4'd1);
          carry = 1'b0;
        end
      end else begin
        incVal[4*i +: 4] = digit;
      end
    end
    incCarry = carry;
  end

  // Ripple decrement: a digit at 0 rolls to 9 and passes the borrow on
  always_comb begin
    logic borrow;
    logic [3:0] digit;
    borrow = 1'b1;
    decVal = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      digit = accQ[4*i +: 4];
      if (borrow) begin
        if (digit == 4'd0) begin
          decVal[4*i +: 4] = 4'd9;
        end else begin
          decVal[4*i +: 4] = 4'(digit - 4'd1);
          borrow = 1'b0;
        end
      end else begin
        decVal[4*i +: 4] = digit;
      end
    end
    decBorrow = borrow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ     <= '0;
      wrapFlag <= 1'b0;
    end else if (strobes.incr) begin
      accQ <= incVal;
      if (incCarry) wrapFlag <= 1'b1;
    end else if (strobes.decr) begin
      accQ <= decVal;
      if (decBorrow) wrapFlag <= 1'b1;
    end
  end

  // Packed BCD orders like binary, so a plain magnitude compare serves
  assign doneFlag = (accQ >= presetBcd);
  assign accBcd   = accQ;
endmodule

// File: rtl/bcd_event_counter.sv
module bcd_event_counter
  import bcd_event_counter_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int ACC_W  = 4 * NUM_DIGITS,
  localparam int WORD_W = ACC_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upCond,
  input  logic              downCond,
  input  logic [ACC_W-1:0]  presetBcd,
  output logic [WORD_W-1:0] statusWord
);
  ctrlStrobes_t     strobes;
  logic             upEn;
  logic             downEn;
  logic [ACC_W-1:0] accBcd;
  logic             doneFlag;
  logic             wrapFlag;

  bcd_count_ctrl u_ctrl (
    .clk      (clk),
    .upCond   (upCond),
    .downCond (downCond),
    .strobes  (strobes),
    .upEn     (upEn),
    .downEn   (downEn)
  );

  bcd_count_datapath #(.NUM_DIGITS(NUM_DIGITS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .presetBcd (presetBcd),
    .accBcd    (accBcd),
    .doneFlag  (doneFlag),
    .wrapFlag  (wrapFlag)
  );

  assign statusWord = {upEn, downEn, doneFlag, wrapFlag, accBcd};
endmodule

// File: rtl/bcd_event_counter_chk.sv
module bcd_event_counter_chk #(
  parameter int NUM_DIGITS = 3,
  localparam int ACC_W  = 4 * NUM_DIGITS,
  localparam int WORD_W = ACC_W + 4
) (
  input logic              clk,
  input logic              rst,
  input logic              upCond,
  input logic              downCond,
  input logic [ACC_W-1:0]  presetBcd,
  input logic [WORD_W-1:0] statusWord
);
  logic [ACC_W-1:0] acc;
  logic wrap, done, upEn, downEn, upRise, downRise;

  assign acc      = statusWord[ACC_W-1:0];
  assign wrap     = statusWord[ACC_W];
  assign done     = statusWord[ACC_W+1];
  assign downEn   = statusWord[ACC_W+2];
  assign upEn     = statusWord[ACC_W+3];
  assign upRise   = upCond & ~upEn;
  assign downRise = downCond & ~downEn;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (acc == '0) && !wrap);

  // R2
  up_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (upRise && !downRise) |=> (acc != $past(acc)));

  // R3
  down_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (downRise && !upRise) |=> (acc != $past(acc)));

  // R5
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> wrap);

  // R6
  done_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    done == (acc >= presetBcd));

  // R7
  up_en_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (upEn == $past(upCond)));

  // R7
  down_en_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (downEn == $past(downCond)));

  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (upRise && downRise) |=> ($stable(acc) && $stable(wrap)));

  // R9
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!upRise && !downRise) |=> $stable(acc));

  // R10
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      acc[4*d +: 4] <= 4'd9);
  end
endmodule

bind bcd_event_counter bcd_event_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .upCond     (upCond),
  .downCond   (downCond),
  .presetBcd  (presetBcd),
  .statusWord (statusWord)
);

// File: tb/test_bcd_event_counter.sv
module test_bcd_event_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upCond = 1'b0;
  logic        downCond = 1'b0;
  logic [11:0] presetBcd = 12'h500;
  logic [15:0] statusWord;

  int checks = 0;
  int errors = 0;
  int expAcc = 0;
  bit expWrap = 1'b0;

  bcd_event_counter i_bcd_event_counter (
    .clk        (clk),
    .rst        (rst),
    .upCond     (upCond),
    .downCond   (downCond),
    .presetBcd  (presetBcd),
    .statusWord (statusWord)
  );

  always #10 clk = ~clk;

  function automatic logic [11:0] toBcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic int fromBcd(logic [11:0] b);
    return int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Checks count, wrap and done against the model
  task automatic checkState(string req);
    check(req, int'(statusWord[11:0]), int'(toBcd(expAcc)));
    check(req, int'(statusWord[12]), int'(expWrap));
    check("R6", int'(statusWord[13]), int'(expAcc >= fromBcd(presetBcd)));
  endtask

  // Change inputs on the falling edge, then wait for the next falling edge
  task automatic step(logic u, logic d);
    upCond = u;
    downCond = d;
    @(negedge clk);
  endtask

  task automatic pulseUp();
    step(1'b1, 1'b0);
    expAcc = (expAcc == 999) ? 0 : expAcc + 1;
    if (expAcc == 0) expWrap = 1'b1;
    step(1'b0, 1'b0);
  endtask

  task automatic pulseDown();
    step(1'b0, 1'b1);
    expAcc = (expAcc == 0) ? 999 : expAcc - 1;
    if (expAcc == 999) expWrap = 1'b1;
    step(1'b0, 1'b0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(1'b0, 1'b0);
    rst = 1'b0;
    expAcc = 0;
    expWrap = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b0, 1'b0);
    // R1: reset state, with a rise of the up condition while in reset
    step(1'b1, 1'b0);
    rst = 1'b0;
    checkState("R1");
    // R4: the held-high level from reset must not count
    step(1'b1, 1'b0);
    checkState("R4");
    check("R7", int'(statusWord[15]), 1);
    step(1'b0, 1'b0);
    check("R7", int'(statusWord[15]), 0);

    // R2 R5 R10: full sweep up through the wrap
    for (int n = 0; n < 1001; n++) begin
      pulseUp();
      checkState("R2");
    end
    // R5: the wrap flag persists across further counts
    check("R5", int'(statusWord[12]), 1);

    // R3 R5: full sweep down from zero through the underflow
    doReset();
    checkState("R1");
    presetBcd = 12'h250;
    for (int n = 0; n < 1001; n++) begin
      pulseDown();
      checkState("R3");
    end

    // R4: a held level counts once only
    doReset();
    step(1'b1, 1'b0);
    expAcc = 1;
    for (int n = 0; n < 5; n++) step(1'b1, 1'b0);
    checkState("R4");
    step(1'b0, 1'b1);
    expAcc = 0;
    for (int n = 0; n < 5; n++) step(1'b0, 1'b1);
    checkState("R4");
    check("R7", int'(statusWord[14]), 1);
    step(1'b0, 1'b0);
    check("R7", int'(statusWord[14]), 0);

    // R8: simultaneous rises cancel, at zero so an underflow would show
    step(1'b1, 1'b1);
    checkState("R8");
    step(1'b0, 1'b0);
    // R8: a rise with the other condition already high still counts
    step(1'b0, 1'b1);
    expAcc = 999;
    expWrap = 1'b1;
    step(1'b1, 1'b1);
    expAcc = 0;
    checkState("R8");
    step(1'b0, 1'b0);

    // R9: idle cycles hold the count
    pulseUp();
    pulseUp();
    for (int n = 0; n < 8; n++) step(1'b0, 1'b0);
    checkState("R9");

    // R10: carry across the middle digit
    doReset();
    for (int n = 0; n < 109; n++) pulseUp();
    check("R10", int'(statusWord[11:0]), int'(12'h109));
    pulseUp();
    check("R10", int'(statusWord[11:0]), int'(12'h110));

    // R6: done around the preset boundary, over several presets
    for (int p = 105; p < 115; p++) begin
      presetBcd = toBcd(p);
      @(negedge clk);
      check("R6", int'(statusWord[13]), int'(110 >= p));
    end

    // R1: reset clears a set wrap flag; enables still track
    pulseDown();
    for (int n = 0; n < 110; n++) pulseDown();
    check("R5", int'(statusWord[12]), 1);
    rst = 1'b1;
    step(1'b1, 1'b1);
    check("R7", int'(statusWord[15:14]), 3);
    rst = 1'b0;
    expAcc = 0;
    expWrap = 1'b0;
    checkState("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule